// File: doc/BRIEF.md
# Fixed-Period Counter-Compare PWM Generator

This block produces a pulse-width-modulated signal with a fixed 1 ms period. A step divider splits the system clock into equal steps. Each step advances a free-running 8-bit phase counter, so one period holds 256 steps. The pad output is high while the phase is at or below the programmed duty value. It is then gated by an enable bit.

The enable bit also drives the pad output-enable. With the enable clear, the pin floats rather than being driven low, and a pull-down on the board must hold it low. The duty value sets a high time of (duty + 1) steps, so the smallest enabled pulse is one step and 0% cannot be produced.

Register writes have no shadow copy. They reach the compare on the clock after the write, at any point in the period. An update in the middle of a period can therefore shorten or stretch the pulse in that period. The phase counter is never disturbed by writes, and it is brought out for observation.

Top module: `fixed_period_pwm`

## Requirements
- R1: After reset the phase output is 0, the duty register is 0, the enable bit is clear, and both pad_oe and pad_out are 0.
- R2: The phase advances by one every TICKS_PER_STEP clocks and wraps from 255 to 0, so one period is 256 × TICKS_PER_STEP clocks.
- R3: Register writes never change the phase sequence; the phase depends only on clocks counted since reset.
- R4: While enabled, pad_out is 1 exactly when phase <= duty, giving (duty + 1) × TICKS_PER_STEP high clocks per period.
- R5: A duty of 255 with enable set keeps pad_out high for the whole period (100%).
- R6: With the enable bit clear, pad_oe is 0 and pad_out is 0, whatever the duty value.
- R7: A write is visible at the pads on the clock edge that accepts it. It is not held back to a period boundary, so raising duty mid-period can raise pad_out at once, and lowering it can drop pad_out at once.
- R8: wr_ready is always 1, and a write is taken on every clock with wr_valid high. wr_sel = 0 loads wr_data into duty. wr_sel = 1 loads wr_data bit 0 into enable.
- R9: No duty value gives a 0% output while enabled: duty 0 still gives TICKS_PER_STEP high clocks per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write acceptance, always high |
| wr_sel | input | 1 | 0 selects duty, 1 selects enable |
| wr_data | input | 8 | Write data (bit 0 only for enable) |
| pad_out | output | 1 | Pad output data |
| pad_oe | output | 1 | Pad output-enable; 0 means high impedance |
| phase | output | 8 | Current phase counter value |

## Verification
The bench builds the block with TICKS_PER_STEP = 2, so a whole period is 512 clocks. At that length, full periods, the 255-to-0 wrap and repeated periods can all be checked cycle by cycle for each duty in the stimulus table. The small divisor still keeps more than one clock per step, so the divider wrap and the hold between steps are both exercised. Writes placed at known phases show the mid-period glitches in both directions.

// File: rtl/pwm_fp_pkg.sv
package pwm_fp_pkg;
  localparam int STEP_W = 8;
  localparam int STEPS  = 1 << STEP_W;
  typedef logic [STEP_W-1:0] step_t;
  typedef enum logic {SEL_DUTY = 1'b0, SEL_EN = 1'b1} wsel_e;
endpackage

// File: rtl/pwm_step_div.sv
module pwm_step_div #(
  parameter int TICKS_PER_STEP = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic step_tick
);
  localparam int CW = (TICKS_PER_STEP > 1) ? $clog2(TICKS_PER_STEP) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_STEP - 1);

  generate
    if (TICKS_PER_STEP == 1) begin : g_every
      assign step_tick = rst_n;
    end else begin : g_count
      logic [CW-1:0] div_q;
      always_ff @(posedge clk) begin
        if (!rst_n)            div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                   div_q <= div_q + 1'b1;
      end
      assign step_tick = (div_q == LAST);

      assert_div_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= LAST);
      assert_div_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step_tick |=> (div_q == '0));
    end
  endgenerate
endmodule

// File: rtl/pwm_phase_ctr.sv
module pwm_phase_ctr
  import pwm_fp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step_tick,
  output step_t phase
);
  step_t phase_q;
  always_ff @(posedge clk) begin
    if (!rst_n)         phase_q <= '0;
    else if (step_tick) phase_q <= phase_q + 1'b1;
  end
  assign phase = phase_q;

  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step_tick |=> (phase_q == step_t'($past(phase_q) + 1'b1)));
  assert_phase_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !step_tick |=> $stable(phase_q));
endmodule

// File: rtl/pwm_ctrl_regs.sv
module pwm_ctrl_regs
  import pwm_fp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_valid,
  input  logic  wr_sel,
  input  step_t wr_data,
  output step_t duty,
  output logic  enable
);
  step_t duty_q;
  logic  en_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty_q <= '0;
      en_q   <= 1'b0;
    end else if (wr_valid) begin
      if (wsel_e'(wr_sel) == SEL_DUTY) duty_q <= wr_data;
      else                             en_q   <= wr_data[0];
    end
  end
  assign duty   = duty_q;
  assign enable = en_q;

  assert_duty_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_sel) |=> (duty_q == $past(wr_data)));
  assert_en_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_sel) |=> $stable(en_q));
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
  import pwm_fp_pkg::*;
(
  input  step_t phase,
  input  step_t duty,
  input  logic  enable,
  output logic  pad_out,
  output logic  pad_oe
);
  logic cmp_hi;
  always_comb begin
    cmp_hi  = (phase <= duty);
    pad_out = cmp_hi & enable;
    pad_oe  = enable;
  end
endmodule

// File: rtl/fixed_period_pwm.sv
module fixed_period_pwm
  import pwm_fp_pkg::*;
#(
  parameter int TICKS_PER_STEP = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic       pad_out,
  output logic       pad_oe,
  output logic [7:0] phase
);
  logic  step_tick;
  step_t phase_w, duty_w;
  logic  en_w;

  assign wr_ready = 1'b1;

  pwm_step_div #(.TICKS_PER_STEP(TICKS_PER_STEP)) u_div (
    .clk(clk), .rst_n(rst_n), .step_tick(step_tick));

  pwm_phase_ctr u_phase (
    .clk(clk), .rst_n(rst_n), .step_tick(step_tick), .phase(phase_w));

  pwm_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sel(wr_sel),
    .wr_data(wr_data), .duty(duty_w), .enable(en_w));

  pwm_out_stage u_out (
    .phase(phase_w), .duty(duty_w), .enable(en_w),
    .pad_out(pad_out), .pad_oe(pad_oe));

  assign phase = phase_w;

  assert_float_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pad_oe |-> !pad_out);
  assert_min_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_w && phase_w == 8'd0) |-> pad_out);
  assert_full_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_w && duty_w == 8'hFF) |-> pad_out);
  assert_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready);
endmodule

// File: tb/fixed_period_pwm_tb.sv
`timescale 1ns/1ps
module fixed_period_pwm_tb;
  localparam int T      = 2;
  localparam int PERIOD = 256 * T;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic wr_ready, pad_out, pad_oe;
  logic [7:0] phase;

  int checks = 0;
  int fails = 0;
  int k = 0;
  logic [7:0] m_duty = '0;
  logic m_en = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fixed_period_pwm #(.TICKS_PER_STEP(T)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_data(wr_data), .pad_out(pad_out), .pad_oe(pad_oe),
    .phase(phase));

  always @(posedge clk) begin
    if (!rst_n) k <= 0;
    else        k <= k + 1;
  end

  function automatic logic [7:0] exp_phase();
    return 8'((k / T) % 256);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    wr_valid = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    if (sel) m_en = d[0]; else m_duty = d;
  endtask

  task automatic chk_cycle(input string req);
    logic e;
    e = m_en & (exp_phase() <= m_duty);
    chk(phase == exp_phase(), "R3 phase", phase, exp_phase());
    chk(pad_out == e, req, pad_out, e);
    chk(pad_oe == m_en, "R6 oe", pad_oe, m_en);
  endtask

  task automatic wait_phase(input logic [7:0] p);
    while (!(exp_phase() == p && (k % T) == 0)) @(negedge clk);
  endtask

  // {enable, duty}
  localparam logic [8:0] VEC [8] = '{
    {1'b1, 8'd0}, {1'b1, 8'd1}, {1'b1, 8'd127}, {1'b1, 8'd254},
    {1'b1, 8'd255}, {1'b0, 8'd200}, {1'b1, 8'd64}, {1'b0, 8'd0}};

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(phase == 0, "R1 phase", phase, 0);
    chk(pad_oe == 0, "R1 oe", pad_oe, 0);
    chk(pad_out == 0, "R1 out", pad_out, 0);
    chk(wr_ready == 1, "R8 ready", wr_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 wrap: phase reaches 255 then 0
    wait_phase(8'd255);
    chk(phase == 8'd255, "R2 top", phase, 255);
    repeat (T) @(negedge clk);
    chk(phase == 8'd0, "R2 wrap", phase, 0);

    // Table walk: R4 R5 R6 R9 high counts per period
    for (int i = 0; i < 8; i++) begin
      int hi;
      int exp_hi;
      wr(1'b0, VEC[i][7:0]);
      wr(1'b1, {7'd0, VEC[i][8]});
      hi = 0;
      for (int c = 0; c < PERIOD; c++) begin
        chk_cycle("R4 compare");
        if (pad_out) hi++;
        @(negedge clk);
      end
      exp_hi = VEC[i][8] ? (int'(VEC[i][7:0]) + 1) * T : 0;
      if (VEC[i][7:0] == 8'd255 && VEC[i][8])
        chk(hi == exp_hi, "R5 full", hi, exp_hi);
      else if (VEC[i][7:0] == 8'd0 && VEC[i][8])
        chk(hi == exp_hi, "R9 min pulse", hi, exp_hi);
      else if (!VEC[i][8])
        chk(hi == 0, "R6 disabled", hi, 0);
      else
        chk(hi == exp_hi, "R4 high count", hi, exp_hi);
    end

    // R7 mid-period glitches
    wr(1'b0, 8'd10);
    wr(1'b1, 8'd1);
    wait_phase(8'd100);
    chk(pad_out == 0, "R7 before raise", pad_out, 0);
    wr(1'b0, 8'd200);
    chk(pad_out == 1, "R7 raise", pad_out, 1);
    chk_cycle("R7 raise model");
    wr(1'b0, 8'd50);
    chk(pad_out == 0, "R7 drop", pad_out, 0);
    chk_cycle("R3 after writes");

    // R8 enable write uses bit 0 only; duty kept
    wr(1'b1, 8'hFE);
    chk(pad_oe == 0, "R8 bit0 only", pad_oe, 0);
    wait_phase(8'd20);
    wr(1'b1, 8'h01);
    chk(pad_out == 1, "R8 duty kept", pad_out, 1);

    // R1 reset mid-run clears registers
    rst_n = 1'b0;
    @(negedge clk);
    chk(phase == 0, "R1 phase rst", phase, 0);
    chk(pad_oe == 0, "R1 oe rst", pad_oe, 0);
    m_duty = '0; m_en = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    wr(1'b1, 8'h01);
    for (int c = 0; c < 3 * T; c++) begin
      chk_cycle("R1 duty reset 0");
      @(negedge clk);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule